// File: doc/BRIEF.md
# Running-Maximum PPM Slot Demodulator

This block turns a stream of digitized photodetector samples into data words for a pulse-position-modulated link. A frame holds `L_SLOTS` slots and carries one pulse; the slot that holds the pulse encodes log2(`L_SLOTS`) bits. An external synchronizer supplies slot and frame markers that arrive with the samples. The block sums the samples of each slot (integrate and dump) and picks the slot with the largest energy. This is the maximum-likelihood decision.

The block does not store all `L_SLOTS` integrals. At each slot boundary it compares the integral that just closed with a single running maximum. It keeps either the old maximum or the new integral, together with the slot number that goes with it. When the last slot of a frame closes, the stored slot number becomes the output word. The first slot of the next frame is already being integrated at that point. Samples can be read as unsigned or as two's complement, chosen by a parameter.

Top module: `ppm_ml_demod`

## Requirements
- R1: Each slot's integral is the sum of the samples accepted while `smp_valid` is 1. A sample accepted together with a slot marker is the first sample of the new slot. The slot that has just closed does not include it.
- R2: The integral of slot 0 of every frame always becomes the stored maximum, with stored index 0, whatever the previous frame held.
- R3: For slots 1 to `L_SLOTS`-1, the stored maximum and index are replaced only when the new integral is strictly greater. On equal integrals the lower slot number is kept.
- R4: `word_valid` is high for exactly one cycle. It goes high in the cycle after the clock edge that accepts the boundary ending slot `L_SLOTS`-1. `word_data` then holds the winning slot number in plain binary (slot 0 is 0, slot k is k) and does not change until the next word.
- R5: Frames may follow each other with no idle cycles. A decision is produced for every complete frame.
- R6: A frame marker accepted with a valid sample starts slot 0. If a frame ends before slot `L_SLOTS`-1 has closed, it produces no word. Slot markers seen before the first frame marker after reset are ignored.
- R7: A slot marker that closes slot `L_SLOTS`-1 without a frame marker produces the decision and starts a new frame at slot 0.
- R8: The integral cannot overflow for up to `MAX_SPS` samples per slot of any sample value.
- R9: With `SIGNED_SAMPLES`=1 the samples are two's complement and the comparison is signed. With 0 they are unsigned.
- R10: While `smp_valid` is 0, the sample value and both markers have no effect.
- R11: After reset, `word_valid` is 0 and `word_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample and markers are valid this cycle |
| smp_data | input | SAMPLE_W | Detector sample |
| slot_start | input | 1 | This sample opens a new slot |
| frame_start | input | 1 | This sample opens slot 0 of a new frame |
| word_valid | output | 1 | One-cycle strobe for a decided word |
| word_data | output | log2(L_SLOTS) | Winning slot number |

## Verification
The bench builds two copies with `L_SLOTS`=4, `SAMPLE_W`=8 and `MAX_SPS`=16, one unsigned and one signed, and drives both with the same stimulus. Byte values of 128 and above then decide differently in the two copies, which exercises the signed comparison path. With four slots, every slot position, the tie rule, truncated frames and wrap-around can all be reached in a few frames. Sixteen samples of 255 reach the accumulator's unsigned limit.

// File: rtl/ppm_demod_pkg.sv
package ppm_demod_pkg;
  // Width of a slot number; at least one bit.
  function automatic int idx_bits(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

  // Integral width: sample, growth for the slot length, plus a sign bit.
  function automatic int acc_bits(input int sample_w, input int max_sps);
    return sample_w + $clog2(max_sps + 1) + 1;
  endfunction
endpackage

// File: rtl/ppm_slot_seq.sv
module ppm_slot_seq #(
  parameter int L_SLOTS = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             slot_start,
  input  logic             frame_start,
  output logic             dump_en,
  output logic [IDX_W-1:0] dump_idx,
  output logic             restart_en,
  output logic             accum_en
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(L_SLOTS - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             boundary;

  always_comb begin
    boundary   = smp_valid & (slot_start | frame_start);
    dump_en    = boundary & active_q;
    restart_en = boundary & (active_q | frame_start);
    accum_en   = smp_valid & active_q & ~boundary;
    dump_idx   = idx_q;

    active_d = active_q | (boundary & frame_start);
    idx_d    = idx_q;
    if (restart_en) begin
      if (frame_start || idx_q == LAST_IDX) idx_d = '0;
      else                                  idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      if (restart_en) idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/ppm_slot_integrator.sv
module ppm_slot_integrator #(
  parameter int SAMPLE_W       = 8,
  parameter int ACC_W          = 14,
  parameter bit SIGNED_SAMPLES = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SAMPLE_W-1:0]     smp_data,
  input  logic                    restart_en,
  input  logic                    accum_en,
  output logic signed [ACC_W-1:0] integral
);
  logic signed [ACC_W-1:0] smp_ext;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  generate
    if (SIGNED_SAMPLES) begin : g_sext
      assign smp_ext = {{(ACC_W-SAMPLE_W){smp_data[SAMPLE_W-1]}}, smp_data};
    end else begin : g_zext
      assign smp_ext = {{(ACC_W-SAMPLE_W){1'b0}}, smp_data};
    end
  endgenerate

  always_comb begin
    acc_d = acc_q;
    if (restart_en)    acc_d = smp_ext;
    else if (accum_en) acc_d = acc_q + smp_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (restart_en || accum_en) acc_q <= acc_d;
  end

  assign integral = acc_q;
endmodule

// File: rtl/ppm_max_tracker.sv
module ppm_max_tracker #(
  parameter int L_SLOTS = 4,
  parameter int IDX_W   = 2,
  parameter int ACC_W   = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dump_en,
  input  logic [IDX_W-1:0]        dump_idx,
  input  logic signed [ACC_W-1:0] integral,
  output logic signed [ACC_W-1:0] max_val,
  output logic [IDX_W-1:0]        max_idx,
  output logic                    word_valid,
  output logic [IDX_W-1:0]        word_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(L_SLOTS - 1);

  logic signed [ACC_W-1:0] max_q, max_d;
  logic [IDX_W-1:0]        midx_q, midx_d;
  logic                    wins, final_dump;
  logic [IDX_W-1:0]        word_q, word_d;
  logic                    valid_q;

  always_comb begin
    wins       = (dump_idx == '0) || (integral > max_q);
    final_dump = dump_en && (dump_idx == LAST_IDX);
    max_d      = wins ? integral : max_q;
    midx_d     = wins ? dump_idx : midx_q;
    word_d     = midx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= '0;
      midx_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= final_dump;
      if (dump_en) begin
        max_q  <= max_d;
        midx_q <= midx_d;
      end
      if (final_dump) word_q <= word_d;
    end
  end

  assign max_val    = max_q;
  assign max_idx    = midx_q;
  assign word_valid = valid_q;
  assign word_data  = word_q;
endmodule

// File: rtl/ppm_ml_demod.sv
module ppm_ml_demod
  import ppm_demod_pkg::*;
#(
  parameter int L_SLOTS        = 4,
  parameter int SAMPLE_W       = 8,
  parameter int MAX_SPS        = 16,
  parameter bit SIGNED_SAMPLES = 1'b0,
  localparam int IDX_W         = idx_bits(L_SLOTS),
  localparam int ACC_W         = acc_bits(SAMPLE_W, MAX_SPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                slot_start,
  input  logic                frame_start,
  output logic                word_valid,
  output logic [IDX_W-1:0]    word_data
);
  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic                    dump_en, restart_en, accum_en;
  logic [IDX_W-1:0]        dump_idx, max_idx;
  logic signed [ACC_W-1:0] integral, max_val;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ppm_slot_seq #(.L_SLOTS(L_SLOTS), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .smp_valid(smp_valid),
    .slot_start(slot_start), .frame_start(frame_start),
    .dump_en(dump_en), .dump_idx(dump_idx),
    .restart_en(restart_en), .accum_en(accum_en)
  );

  ppm_slot_integrator #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W),
                        .SIGNED_SAMPLES(SIGNED_SAMPLES)) integ_i (
    .clk(clk), .rst_n(rst_sync_n), .smp_data(smp_data),
    .restart_en(restart_en), .accum_en(accum_en), .integral(integral)
  );

  ppm_max_tracker #(.L_SLOTS(L_SLOTS), .IDX_W(IDX_W), .ACC_W(ACC_W)) track_i (
    .clk(clk), .rst_n(rst_sync_n), .dump_en(dump_en), .dump_idx(dump_idx),
    .integral(integral), .max_val(max_val), .max_idx(max_idx),
    .word_valid(word_valid), .word_data(word_data)
  );
endmodule

// File: rtl/ppm_ml_demod_chk.sv
module ppm_ml_demod_chk #(
  parameter int L_SLOTS = 4,
  parameter int IDX_W   = 2,
  parameter int ACC_W   = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dump_en,
  input logic [IDX_W-1:0]        dump_idx,
  input logic signed [ACC_W-1:0] max_val,
  input logic [IDX_W-1:0]        max_idx,
  input logic                    word_valid,
  input logic [IDX_W-1:0]        word_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(L_SLOTS - 1);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R4
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(dump_en && dump_idx == LAST_IDX));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));

  // R2
  slot0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_en && dump_idx == '0) |=> (max_idx == '0));

  // R3
  max_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_en && dump_idx != '0) |=> (max_val >= $past(max_val)));
endmodule

bind ppm_ml_demod ppm_ml_demod_chk #(.L_SLOTS(L_SLOTS), .IDX_W(IDX_W), .ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .dump_en(dump_en), .dump_idx(dump_idx),
  .max_val(max_val), .max_idx(max_idx),
  .word_valid(word_valid), .word_data(word_data)
);

// File: tb/ppm_ml_demod_tb_top.sv
`timescale 1ns/1ps
module ppm_ml_demod_tb_top;
  localparam int L   = 4;
  localparam int SW  = 8;
  localparam int SPS = 16;
  localparam int IW  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, smp_valid, slot_start, frame_start;
  logic [SW-1:0] smp_data;
  logic          u_valid, s_valid;
  logic [IW-1:0] u_data, s_data;

  int errors = 0;
  int checks = 0;
  int slotv [L][SPS];
  int nsmp   = 4;
  int gap_at = -1;
  bit exp_v  = 1'b0;
  int exp_u, exp_s;
  string exp_tag = "R4";
  bit done = 1'b0;

  ppm_ml_demod #(.L_SLOTS(L), .SAMPLE_W(SW), .MAX_SPS(SPS), .SIGNED_SAMPLES(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .slot_start(slot_start), .frame_start(frame_start),
    .word_valid(u_valid), .word_data(u_data));

  ppm_ml_demod #(.L_SLOTS(L), .SAMPLE_W(SW), .MAX_SPS(SPS), .SIGNED_SAMPLES(1'b1)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .slot_start(slot_start), .frame_start(frame_start),
    .word_valid(s_valid), .word_data(s_data));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int d, input bit ss, input bit fs);
    @(negedge clk);
    smp_valid = v; smp_data = SW'(d); slot_start = ss; frame_start = fs;
    @(posedge clk);
    #1;
  endtask

  task automatic fill(input int a, input int b, input int c, input int e);
    for (int k = 0; k < SPS; k++) begin
      slotv[0][k] = a; slotv[1][k] = b; slotv[2][k] = c; slotv[3][k] = e;
    end
  endtask

  // Compare the word produced at this boundary with the pending expectation.
  task automatic check_boundary();
    chk({exp_tag, " valid unsigned"}, int'(u_valid), int'(exp_v));
    chk({exp_tag, " valid signed"}, int'(s_valid), int'(exp_v));
    if (exp_v) begin
      chk({exp_tag, " word unsigned"}, int'(u_data), exp_u);
      chk({exp_tag, " word signed"}, int'(s_data), exp_s);
    end
  endtask

  task automatic send_frame(input int nsl, input bit fs, input string tag);
    int su [L];
    int sg [L];
    int extra = 0;
    int bu = 0, bs = 0;
    for (int s = 0; s < nsl; s++) begin
      su[s] = 0; sg[s] = 0;
      for (int k = 0; k < nsmp; k++) begin
        if (k == gap_at && k > 0) begin
          // R10: idle cycle carrying a large value and both markers
          step(1'b0, 255, 1'b1, 1'b1);
          if (u_valid || s_valid) extra++;
        end
        step(1'b1, slotv[s][k], k == 0, fs && s == 0 && k == 0);
        if (s == 0 && k == 0) check_boundary();
        else if (u_valid || s_valid) extra++;
        su[s] += slotv[s][k];
        sg[s] += (slotv[s][k] >= 128) ? slotv[s][k] - 256 : slotv[s][k];
      end
    end
    chk({tag, " R4 no extra valid"}, extra, 0);
    exp_tag = tag;
    exp_v   = (nsl == L);
    for (int s = 1; s < nsl; s++) begin
      if (su[s] > su[bu]) bu = s;
      if (sg[s] > sg[bs]) bs = s;
    end
    exp_u = bu; exp_s = bs;
  endtask

  task automatic flush();
    step(1'b1, 0, 1'b1, 1'b1);
    check_boundary();
    exp_v = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 valid after reset", int'(u_valid), 0);
    chk("R11 word after reset", int'(u_data), 0);
    chk("R11 word after reset signed", int'(s_data), 0);
  endtask

  task automatic t_basic();
    nsmp = 4; gap_at = -1;
    fill(10, 20, 90, 30);  send_frame(L, 1'b1, "R4 slot2");
    fill(100, 5, 5, 5);    send_frame(L, 1'b1, "R5 slot0");
    fill(1, 2, 3, 4);      send_frame(L, 1'b1, "R5 slot3");
  endtask

  task automatic t_tie();
    fill(5, 50, 7, 50);    send_frame(L, 1'b1, "R3 tie");
    fill(9, 9, 9, 9);      send_frame(L, 1'b1, "R3 all equal");
  endtask

  task automatic t_first();
    fill(120, 120, 120, 121); send_frame(L, 1'b1, "R3 big");
    fill(3, 1, 1, 1);         send_frame(L, 1'b1, "R2 reload");
    fill(0, 0, 0, 0);         send_frame(L, 1'b1, "R2 zeros");
  endtask

  task automatic t_gap();
    nsmp = 5; gap_at = 2;
    fill(10, 10, 60, 10);  send_frame(L, 1'b1, "R1 R10 gaps");
    fill(40, 39, 41, 40);  send_frame(L, 1'b1, "R1 close");
    gap_at = -1; nsmp = 4;
  endtask

  task automatic t_short();
    fill(1, 99, 1, 1);     send_frame(2, 1'b1, "R6 short");
    fill(1, 2, 40, 3);     send_frame(L, 1'b1, "R6 after short");
  endtask

  task automatic t_wrap();
    fill(4, 4, 4, 70);     send_frame(L, 1'b1, "R7 before wrap");
    fill(60, 1, 1, 1);     send_frame(L, 1'b0, "R7 wrapped");
  endtask

  task automatic t_ovf();
    nsmp = SPS;
    fill(128, 255, 0, 255);
    slotv[3][SPS-1] = 0;
    // unsigned: 2048, 4080, 0, 3825 -> 1; signed: -2048, -16, 0, -15 -> 2
    send_frame(L, 1'b1, "R8 R9 extremes");
    flush();
    nsmp = 4;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; slot_start = 1'b0; frame_start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    // R6: slot marker before any frame marker is ignored
    step(1'b1, 200, 1'b1, 1'b0);
    chk("R6 pre-frame marker", int'(u_valid), 0);
    t_basic();
    t_tie();
    t_first();
    t_gap();
    t_short();
    t_wrap();
    t_ovf();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule